// File: doc/BRIEF.md
# Link-side register access engine for an 8-bit PHY data bus

This block sits on the link side of an 8-bit PHY data bus that uses a direction line (`ulpi_dir`), a next/accept strobe (`ulpi_nxt`) and a stop strobe (`ulpi_stp`). It turns single register read and write requests from a host-side request port into transmit command sequences on that bus. It reports each request as done (with read data for a read) or as aborted.

Every request is encoded as a command byte. Bits [7:6] give the access type and bits [5:0] carry either the register address itself or an escape payload. The escape payload means the full 8-bit address follows as its own byte. The engine picks the form from the address value.

The PHY may take the bus at any moment by raising `ulpi_dir`. The engine then stops driving at once, and an access that has not finished its outgoing bytes is reported as aborted. The requester is expected to retry it.

Top module: `ulpi_reg_engine`

## Requirements
- R1: After reset the engine is idle: `ulpi_data_out` is 00h, `ulpi_stp` is 0, `rsp_valid` is 0, and `req_ready` is 1 while `ulpi_dir` is low.
- R2: The first byte of an access is the command byte: bits [7:6] are 10b for a write and 11b for a read, and for an address from 00h to 2Eh bits [5:0] hold that address.
- R3: An address of 2Fh or above is sent in extended form: the command byte carries payload 2Fh in bits [5:0], and once that byte is accepted the full 8-bit address is driven as the next byte.
- R4: Each outgoing byte (command, extended address, write data) stays on the bus unchanged until the cycle in which `ulpi_nxt` is sampled high.
- R5: For a write, the cycle after the data byte is accepted drives `ulpi_stp` high for exactly one cycle with data 00h. `rsp_valid` with `rsp_abort`=0 follows in the next cycle.
- R6: For a read, after the address is accepted the PHY raises `ulpi_dir`. The first cycle with `ulpi_dir` high is turnaround, and `ulpi_data_in` is captured in the cycle after it. `rsp_valid` with `rsp_abort`=0 and `rsp_rdata` equal to the captured byte comes in the cycle after `ulpi_dir` is first seen low again.
- R7: If `ulpi_dir` is high while a command, extended address or write data byte is waiting for acceptance, the access ends. `rsp_valid` with `rsp_abort`=1 comes in the next cycle, and no stop pulse is driven.
- R8: `ulpi_data_oe` is 0 in every cycle in which `ulpi_dir` is 1.
- R9: `req_ready` is 1 only when the engine is idle and `ulpi_dir` is low. A request presented while `req_ready` is 0 is ignored and does not change the bytes of the access in flight.
- R10: With extended addressing disabled (`EXT_EN`=0), a request for an address of 2Fh or above is answered in the next cycle with `rsp_valid` and `rsp_abort`=1, and nothing is driven on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request accepted in this cycle if `req_valid` is high |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_abort | output | 1 | Response is an abort (valid with `rsp_valid`) |
| rsp_rdata | output | 8 | Read data (valid with `rsp_valid` for a completed read) |
| ulpi_dir | input | 1 | PHY owns the bus when high |
| ulpi_nxt | input | 1 | PHY accepts the byte driven in this cycle |
| ulpi_data_in | input | 8 | Data bus as driven by the PHY |
| ulpi_data_out | output | 8 | Data bus value driven by the link |
| ulpi_data_oe | output | 1 | Link drive enable for the data bus |
| ulpi_stp | output | 1 | Stop strobe |

## Verification
The command byte is due in the cycle after the request is accepted. Each later byte is due in the cycle after the previous byte's acceptance. The stop pulse comes one cycle after the write data is accepted, and the write response one cycle after that. A read response appears one cycle after the direction line is seen low, and an abort one cycle after the direction line rises during a byte wait. The bench drives inputs on the falling edge and compares outputs on the falling edge that follows the rising edge at which each result is registered. It walks through the PHY handshake with random acceptance delays and random takeovers, and it computes each expected byte and response from the address and access type alone.

// File: rtl/ulpi_reg_pkg.sv
package ulpi_reg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CMD  = 3'd1,
    ST_EADR = 3'd2,
    ST_WDAT = 3'd3,
    ST_STP  = 3'd4,
    ST_TURN = 3'd5,
    ST_RDAT = 3'd6,
    ST_REL  = 3'd7
  } eng_state_t;

  localparam logic [1:0] OP_WRITE = 2'b10;
  localparam logic [1:0] OP_READ  = 2'b11;

endpackage

// File: rtl/ulpi_cmd_build.sv
module ulpi_cmd_build #(
  parameter int DATA_W = 8,
  parameter int IMM_W  = 6,
  parameter logic [IMM_W-1:0] ESC_CODE = 6'h2F,
  parameter bit EXT_EN = 1'b1
) (
  input  logic              is_write,
  input  logic [DATA_W-1:0] addr,
  output logic [DATA_W-1:0] cmd_byte,
  output logic              use_ext,
  output logic              reject
);
  import ulpi_reg_pkg::*;

  localparam int OP_W = DATA_W - IMM_W;
  localparam logic [DATA_W-1:0] ESC_WIDE = {{OP_W{1'b0}}, ESC_CODE};

  logic [OP_W-1:0]  op_code;
  logic [IMM_W-1:0] payload;

  // Addresses at or above the escape code cannot travel in the immediate field.
  assign use_ext  = (addr >= ESC_WIDE);
  assign op_code  = is_write ? OP_WRITE : OP_READ;
  assign payload  = use_ext ? ESC_CODE : addr[IMM_W-1:0];
  assign cmd_byte = {op_code, payload};

  generate
    if (EXT_EN) begin : g_ext_on
      assign reject = 1'b0;
    end else begin : g_ext_off
      assign reject = use_ext;
    end
  endgenerate

endmodule

// File: rtl/ulpi_reg_fsm.sv
module ulpi_reg_fsm #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] cmd_byte,
  input  logic              use_ext,
  input  logic              reject,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_abort,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              ulpi_dir,
  input  logic              ulpi_nxt,
  input  logic [DATA_W-1:0] ulpi_data_in,
  output logic [DATA_W-1:0] ulpi_data_out,
  output logic              ulpi_data_oe,
  output logic              ulpi_stp
);
  import ulpi_reg_pkg::*;

  eng_state_t        st_q, st_d;
  logic              accept;
  logic              fire_d, abort_d;
  logic              write_q, ext_q;
  logic [DATA_W-1:0] cmd_q, addr_q, wdata_q;

  assign req_ready = (st_q == ST_IDLE) && !ulpi_dir;
  assign accept    = req_valid && req_ready;

  // Next-state and response decode
  always_comb begin
    st_d    = st_q;
    fire_d  = 1'b0;
    abort_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (reject) begin
            fire_d  = 1'b1;
            abort_d = 1'b1;
          end else begin
            st_d = ST_CMD;
          end
        end
      end
      ST_CMD, ST_EADR, ST_WDAT: begin
        if (ulpi_dir) begin
          st_d    = ST_IDLE;
          fire_d  = 1'b1;
          abort_d = 1'b1;
        end else if (ulpi_nxt) begin
          if (st_q == ST_WDAT)                  st_d = ST_STP;
          else if (st_q == ST_CMD && ext_q)     st_d = ST_EADR;
          else if (write_q)                     st_d = ST_WDAT;
          else                                  st_d = ST_TURN;
        end
      end
      ST_STP: begin
        st_d   = ST_IDLE;
        fire_d = 1'b1;
      end
      ST_TURN: begin
        if (ulpi_dir) st_d = ST_RDAT;
      end
      ST_RDAT: st_d = ST_REL;
      ST_REL: begin
        if (!ulpi_dir) begin
          st_d   = ST_IDLE;
          fire_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // State and response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      rsp_valid <= 1'b0;
      rsp_abort <= 1'b0;
    end else begin
      st_q      <= st_d;
      rsp_valid <= fire_d;
      rsp_abort <= abort_d;
    end
  end

  // Request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      ext_q   <= 1'b0;
      cmd_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      write_q <= req_write;
      ext_q   <= use_ext;
      cmd_q   <= cmd_byte;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  // Read data capture, enabled in the sample cycle after turnaround
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
    end else if (st_q == ST_RDAT) begin
      rsp_rdata <= ulpi_data_in;
    end
  end

  // Bus outputs
  always_comb begin
    case (st_q)
      ST_CMD:  ulpi_data_out = cmd_q;
      ST_EADR: ulpi_data_out = addr_q;
      ST_WDAT: ulpi_data_out = wdata_q;
      default: ulpi_data_out = '0;
    endcase
  end

  assign ulpi_stp     = (st_q == ST_STP);
  assign ulpi_data_oe = !ulpi_dir;

  AST_NO_DRIVE_ON_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    ulpi_dir |-> !ulpi_data_oe); // R8

  AST_HOLD_UNTIL_NXT: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_CMD || st_q == ST_EADR || st_q == ST_WDAT) && !ulpi_nxt && !ulpi_dir)
      |=> $stable(ulpi_data_out)); // R4

  AST_STP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ulpi_stp |=> !ulpi_stp); // R5

  AST_STP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ulpi_stp |-> $past(ulpi_nxt)); // R5

  AST_DONE_AFTER_STP: assert property (@(posedge clk) disable iff (!rst_n)
    ulpi_stp |=> (rsp_valid && !rsp_abort)); // R5

  AST_ABORT_ON_TAKEOVER: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_CMD || st_q == ST_EADR || st_q == ST_WDAT) && ulpi_dir)
      |=> (rsp_valid && rsp_abort && !ulpi_stp)); // R7

  AST_READY_ONLY_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ulpi_dir); // R9

endmodule

// File: rtl/ulpi_reg_engine.sv
module ulpi_reg_engine #(
  parameter int DATA_W = 8,
  parameter int IMM_W  = 6,
  parameter logic [IMM_W-1:0] ESC_CODE = 6'h2F,
  parameter bit EXT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_abort,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              ulpi_dir,
  input  logic              ulpi_nxt,
  input  logic [DATA_W-1:0] ulpi_data_in,
  output logic [DATA_W-1:0] ulpi_data_out,
  output logic              ulpi_data_oe,
  output logic              ulpi_stp
);

  logic [DATA_W-1:0] cmd_byte;
  logic              use_ext;
  logic              reject;

  ulpi_cmd_build #(
    .DATA_W  (DATA_W),
    .IMM_W   (IMM_W),
    .ESC_CODE(ESC_CODE),
    .EXT_EN  (EXT_EN)
  ) u_cmd (
    .is_write(req_write),
    .addr    (req_addr),
    .cmd_byte(cmd_byte),
    .use_ext (use_ext),
    .reject  (reject)
  );

  ulpi_reg_fsm #(
    .DATA_W(DATA_W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .cmd_byte     (cmd_byte),
    .use_ext      (use_ext),
    .reject       (reject),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_abort    (rsp_abort),
    .rsp_rdata    (rsp_rdata),
    .ulpi_dir     (ulpi_dir),
    .ulpi_nxt     (ulpi_nxt),
    .ulpi_data_in (ulpi_data_in),
    .ulpi_data_out(ulpi_data_out),
    .ulpi_data_oe (ulpi_data_oe),
    .ulpi_stp     (ulpi_stp)
  );

endmodule

// File: tb/ulpi_reg_engine_tb.sv
module ulpi_reg_engine_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic       req_valid, req_write;
  logic [7:0] req_addr, req_wdata;
  logic       req_ready, rsp_valid, rsp_abort;
  logic [7:0] rsp_rdata;
  logic       ulpi_dir, ulpi_nxt;
  logic [7:0] ulpi_data_in, ulpi_data_out;
  logic       ulpi_data_oe, ulpi_stp;

  logic       n_req_valid;
  logic [7:0] n_req_addr;
  logic       n_req_ready, n_rsp_valid, n_rsp_abort;
  logic [7:0] n_rsp_rdata, n_data_out;
  logic       n_data_oe, n_stp;

  int checks;
  int errors;

  ulpi_reg_engine u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_abort(rsp_abort), .rsp_rdata(rsp_rdata),
    .ulpi_dir(ulpi_dir), .ulpi_nxt(ulpi_nxt),
    .ulpi_data_in(ulpi_data_in), .ulpi_data_out(ulpi_data_out),
    .ulpi_data_oe(ulpi_data_oe), .ulpi_stp(ulpi_stp)
  );

  ulpi_reg_engine #(.EXT_EN(1'b0)) u_dut_noext (
    .clk(clk), .rst_n(rst_n),
    .req_valid(n_req_valid), .req_write(1'b0),
    .req_addr(n_req_addr), .req_wdata(8'h00),
    .req_ready(n_req_ready), .rsp_valid(n_rsp_valid),
    .rsp_abort(n_rsp_abort), .rsp_rdata(n_rsp_rdata),
    .ulpi_dir(1'b0), .ulpi_nxt(1'b0),
    .ulpi_data_in(8'h00), .ulpi_data_out(n_data_out),
    .ulpi_data_oe(n_data_oe), .ulpi_stp(n_stp)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_cmd(input bit w, input logic [7:0] a);
    logic [5:0] pl;
    pl = (a >= 8'h2F) ? 6'h2F : a[5:0];
    return {(w ? 2'b10 : 2'b11), pl};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // abort_ph: byte phase in which the PHY takes the bus (-1 for none)
  task automatic run_txn(input bit w, input logic [7:0] a, input logic [7:0] d,
                         input logic [7:0] rd, input int abort_ph, input int maxdly);
    logic [7:0] bytes [3];
    int nb;
    bit ext;
    ext = (a >= 8'h2F);
    bytes[0] = exp_cmd(w, a);
    bytes[1] = ext ? a : d;
    bytes[2] = d;
    nb = 1 + int'(ext) + int'(w);

    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready when idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);

    for (int p = 0; p < nb; p++) begin
      int dly;
      dly = $urandom_range(0, maxdly);
      for (int c = 0; c <= dly; c++) begin
        @(negedge clk);
        ulpi_nxt = 1'b0;
        req_valid = 1'b0;
        if (p == 0)
          chk(ulpi_data_out == bytes[p] && ulpi_data_oe && !ulpi_stp, "R2 command byte",
              32'(ulpi_data_out), 32'(bytes[p]));
        else if (p == 1 && ext)
          chk(ulpi_data_out == bytes[p] && ulpi_data_oe, "R3 extended address byte",
              32'(ulpi_data_out), 32'(bytes[p]));
        else
          chk(ulpi_data_out == bytes[p] && ulpi_data_oe, "R4 write data byte",
              32'(ulpi_data_out), 32'(bytes[p]));
        chk(req_ready == 1'b0, "R9 not ready while busy", 32'(req_ready), 32'd0);
        if (p == abort_ph && c == dly) begin
          ulpi_dir = 1'b1;
          #1;
          chk(ulpi_data_oe == 1'b0, "R8 released on takeover", 32'(ulpi_data_oe), 32'd0);
          @(posedge clk);
          @(negedge clk);
          chk(rsp_valid && rsp_abort, "R7 abort response",
              {30'd0, rsp_valid, rsp_abort}, 32'd3);
          chk(ulpi_stp == 1'b0, "R7 no stop on abort", 32'(ulpi_stp), 32'd0);
          chk(req_ready == 1'b0, "R9 not ready while dir high", 32'(req_ready), 32'd0);
          @(posedge clk);
          @(negedge clk);
          ulpi_dir = 1'b0;
          return;
        end
        if (c == dly) begin
          ulpi_nxt = 1'b1;
        end else begin
          // competing request while busy must be ignored
          req_valid = 1'b1; req_write = ~w; req_addr = $urandom; req_wdata = $urandom;
        end
        @(posedge clk);
      end
    end

    @(negedge clk);
    ulpi_nxt = 1'b0;
    req_valid = 1'b0;
    if (w) begin
      chk(ulpi_stp && ulpi_data_out == 8'h00, "R5 stop pulse with idle data",
          {23'd0, ulpi_stp, ulpi_data_out}, 32'h100);
      @(posedge clk);
      @(negedge clk);
      chk(rsp_valid && !rsp_abort && !ulpi_stp, "R5 write done",
          {29'd0, rsp_valid, rsp_abort, ulpi_stp}, 32'd4);
    end else begin
      int extra;
      ulpi_dir = 1'b1;
      #1;
      chk(ulpi_data_oe == 1'b0, "R8 no drive in turnaround", 32'(ulpi_data_oe), 32'd0);
      @(posedge clk);
      @(negedge clk);
      ulpi_data_in = rd;
      @(posedge clk);
      @(negedge clk);
      ulpi_data_in = ~rd;
      extra = $urandom_range(0, 2);
      for (int k = 0; k < extra; k++) begin
        chk(rsp_valid == 1'b0, "R6 no response while dir high", 32'(rsp_valid), 32'd0);
        @(posedge clk);
        @(negedge clk);
      end
      ulpi_dir = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(rsp_valid && !rsp_abort && rsp_rdata == rd, "R6 read data",
          {22'd0, rsp_valid, rsp_abort, rsp_rdata}, {22'd0, 2'b10, rd});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    checks = 0; errors = 0;
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    ulpi_dir = 1'b0; ulpi_nxt = 1'b0; ulpi_data_in = '0;
    n_req_valid = 1'b0; n_req_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ulpi_data_out == 8'h00 && !ulpi_stp && !rsp_valid && req_ready, "R1 reset state",
        {21'd0, ulpi_stp, rsp_valid, req_ready, ulpi_data_out}, 32'h100);

    // directed corners
    run_txn(1'b1, 8'h00, 8'hA5, 8'h00, -1, 0);
    run_txn(1'b1, 8'h2E, 8'h5A, 8'h00, -1, 2);
    run_txn(1'b1, 8'h2F, 8'h3C, 8'h00, -1, 1);
    run_txn(1'b1, 8'hFF, 8'hC3, 8'h00, -1, 3);
    run_txn(1'b0, 8'h2E, 8'h00, 8'h81, -1, 2);
    run_txn(1'b0, 8'h2F, 8'h00, 8'h7E, -1, 0);
    run_txn(1'b0, 8'h80, 8'h00, 8'h11, 0, 0);
    run_txn(1'b1, 8'h40, 8'h22, 8'h00, 1, 2);
    run_txn(1'b1, 8'h40, 8'h22, 8'h00, 2, 1);
    run_txn(1'b1, 8'h10, 8'h99, 8'h00, 1, 0);

    // constrained random
    for (int i = 0; i < 120; i++) begin
      bit w;
      logic [7:0] a;
      int ab;
      int sel;
      w = 1'($urandom_range(0, 1));
      sel = $urandom_range(0, 3);
      a = (sel == 0) ? 8'($urandom_range(8'h2D, 8'h30)) : 8'($urandom);
      ab = ($urandom_range(0, 99) < 15) ? $urandom_range(0, 2) : -1;
      run_txn(w, a, 8'($urandom), 8'($urandom), ab, 3);
    end

    // R10: extended form disabled
    @(negedge clk);
    n_req_valid = 1'b1; n_req_addr = 8'h30;
    @(posedge clk);
    @(negedge clk);
    n_req_valid = 1'b0;
    chk(n_rsp_valid && n_rsp_abort, "R10 reject extended address",
        {30'd0, n_rsp_valid, n_rsp_abort}, 32'd3);
    chk(n_data_out == 8'h00 && !n_stp, "R10 bus untouched",
        {23'd0, n_stp, n_data_out}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule